// File: doc/BRIEF.md
# Core-War Instruction Execute Unit

This unit is the final stage of a core-war virtual machine pipeline. An upstream resolver has already fetched the current instruction and evaluated both operands, so each operand arrives as a core address plus the word found there. The unit applies the opcode's effect. It can issue one write through the core memory write port. It also tells the task scheduler how the task proceeds: it continues at a new PC, it dies, or it forks a second task.

Fields and addresses are unsigned values in the range 0 to M-1, where M is the core size. Every sum, difference and PC advance wraps modulo M. The A operand's addressing mode selects the form of MOV, ADD, SUB and CMP. When A is immediate, these opcodes act on a single field. Otherwise they act on the whole word. One valid input produces one registered result on the next clock edge.

Top module: `cw_exec_unit`

## Requirements
- R1: During and immediately after a synchronous reset, out_valid, mem_we, kill and split are all 0.
- R2: A result appears exactly one cycle after in_valid is high. A cycle with in_valid low yields out_valid, mem_we, kill and split all 0 on the next cycle.
- R3: Opcode 0 (DAT) and the unassigned opcodes 11 to 15 raise kill. They perform no write and no split, and next_pc reports pc+1.
- R4: MOV (opcode 1) writes to the B address. With an immediate A (A mode 0), the write is the B word with its B-field replaced by the instruction's A-field. Otherwise the whole A word is written.
- R5: ADD (opcode 2) with an immediate A adds the instruction's A-field to the B word's B-field. Otherwise it adds the A word's A-field and B-field to the B word's A-field and B-field. The result is written to the B address.
- R6: SUB (opcode 3) has the same forms as ADD but subtracts the A quantity from the B quantity.
- R7: JMP (4) sets next_pc to the A address. JMZ (5) does so only when the B word's B-field is 0, and JMN (6) only when it is non-zero. A branch that is not taken gives pc+1.
- R8: DJN (7) writes the B word with its B-field decremented by one modulo M. It jumps to the A address when the decremented value is non-zero.
- R9: CMP (8) compares the instruction's A-field with the B word's B-field when A is immediate, and the whole A and B words otherwise. On equality next_pc is pc+2.
- R10: SLT (9) takes pc+2 when the A value is strictly less than the B word's B-field, comparing unsigned. The A value is the instruction's A-field when A is immediate and the A word's B-field otherwise.
- R11: SPL (10) raises split with split_pc equal to the A address and next_pc equal to pc+1. It performs no write.
- R12: All written fields, next_pc and split_pc lie in 0 to M-1. Increments and sums past M-1 wrap, and differences below 0 wrap.

Word layout, most significant bit first: opcode[3:0], A mode[1:0], B mode[1:0], A-field[ADDR_W-1:0], B-field[ADDR_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction are valid this cycle |
| pc | input | ADDR_W | Address of the executing instruction |
| instr | input | WORD_W | Executing instruction word |
| a_addr | input | ADDR_W | Resolved A operand address |
| a_word | input | WORD_W | Word at the A address |
| b_addr | input | ADDR_W | Resolved B operand address |
| b_word | input | WORD_W | Word at the B address |
| out_valid | output | 1 | Result valid |
| next_pc | output | ADDR_W | Continuation PC of the task |
| kill | output | 1 | Task is removed |
| split | output | 1 | A new task is created |
| split_pc | output | ADDR_W | PC of the new task |
| mem_we | output | 1 | Core write enable |
| mem_waddr | output | ADDR_W | Core write address |
| mem_wdata | output | WORD_W | Core write data |

## Verification
On every cycle, the embedded assertions check the one-cycle valid pipeline, the range of every produced PC and modular result, and the exclusivity of kill against write and split. Whether a given opcode and mode pair gives the right write data, and which way a branch, skip or decrement-and-jump resolves, depends on the data. Only the bench's reference model can show that, driven by random vectors and by directed wrap cases at M-1 and 0.

// File: rtl/cw_pkg.sv
package cw_pkg;
  parameter int CORE_SIZE = 8000;
  localparam int ADDR_W = $clog2(CORE_SIZE);
  localparam int OP_W = 4;
  localparam int MODE_W = 2;

  localparam logic [OP_W-1:0] OP_DAT = 4'd0;
  localparam logic [OP_W-1:0] OP_MOV = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB = 4'd3;
  localparam logic [OP_W-1:0] OP_JMP = 4'd4;
  localparam logic [OP_W-1:0] OP_JMZ = 4'd5;
  localparam logic [OP_W-1:0] OP_JMN = 4'd6;
  localparam logic [OP_W-1:0] OP_DJN = 4'd7;
  localparam logic [OP_W-1:0] OP_CMP = 4'd8;
  localparam logic [OP_W-1:0] OP_SLT = 4'd9;
  localparam logic [OP_W-1:0] OP_SPL = 4'd10;

  localparam logic [MODE_W-1:0] MD_IMM = 2'd0;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [MODE_W-1:0] amode;
    logic [MODE_W-1:0] bmode;
    logic [ADDR_W-1:0] af;
    logic [ADDR_W-1:0] bf;
  } word_t;

  localparam int WORD_W = $bits(word_t);
endpackage

// File: rtl/cw_mod_addsub.sv
module cw_mod_addsub #(
  parameter int M = 8000,
  parameter int W = 13
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] r
);
  localparam logic [W:0] MV = (W+1)'(M);
  logic [W:0] s;

  always_comb begin
    if (!sub) begin
      s = {1'b0, x} + {1'b0, y};
      if (s >= MV) s = s - MV;
    end else if (x >= y) begin
      s = {1'b0, x} - {1'b0, y};
    end else begin
      s = {1'b0, x} + MV - {1'b0, y};
    end
  end

  assign r = s[W-1:0];

  // R12
  always_comb begin
    if (x < MV && y < MV) begin
      res_range_chk: assert (s < MV);
    end
  end
endmodule

// File: rtl/cw_field_alu.sv
module cw_field_alu #(
  parameter int M = 8000,
  parameter int W = 13
) (
  input  logic [3:0]   op,
  input  logic         a_imm,
  input  logic [W-1:0] imm_val,
  input  logic [W-1:0] a_af,
  input  logic [W-1:0] a_bf,
  input  logic [W-1:0] b_af,
  input  logic [W-1:0] b_bf,
  output logic [W-1:0] new_af,
  output logic [W-1:0] new_bf
);
  localparam int LANES = 2;
  logic [W-1:0] xs [LANES];
  logic [W-1:0] ys [LANES];
  logic [W-1:0] rs [LANES];
  logic         subs [LANES];

  logic is_djn, is_sub;
  assign is_djn = (op == cw_pkg::OP_DJN);
  assign is_sub = (op == cw_pkg::OP_SUB);

  // lane 0: A-field, lane 1: B-field
  assign xs[0]   = b_af;
  assign ys[0]   = a_af;
  assign subs[0] = is_sub;
  assign xs[1]   = b_bf;
  assign ys[1]   = is_djn ? W'(1) : (a_imm ? imm_val : a_bf);
  assign subs[1] = is_sub | is_djn;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    cw_mod_addsub #(.M(M), .W(W)) u_as (
      .x(xs[i]), .y(ys[i]), .sub(subs[i]), .r(rs[i])
    );
  end

  assign new_af = rs[0];
  assign new_bf = rs[1];
endmodule

// File: rtl/cw_branch.sv
module cw_branch #(
  parameter int M = 8000,
  parameter int W = 13,
  parameter int WW = 34
) (
  input  logic [3:0]    op,
  input  logic          a_imm,
  input  logic [W-1:0]  pc,
  input  logic [W-1:0]  imm_val,
  input  logic [W-1:0]  a_addr,
  input  logic [WW-1:0] a_word,
  input  logic [W-1:0]  a_bf,
  input  logic [WW-1:0] b_word,
  input  logic [W-1:0]  b_bf,
  input  logic [W-1:0]  djn_bf,
  output logic [W-1:0]  next_pc,
  output logic          kill,
  output logic          split,
  output logic [W-1:0]  split_pc
);
  logic [W-1:0] pc_p1, pc_p2;
  logic         cmp_eq, slt_lt;
  logic [W-1:0] slt_a;

  cw_mod_addsub #(.M(M), .W(W)) u_inc1 (
    .x(pc), .y(W'(1)), .sub(1'b0), .r(pc_p1)
  );
  cw_mod_addsub #(.M(M), .W(W)) u_inc2 (
    .x(pc), .y(W'(2)), .sub(1'b0), .r(pc_p2)
  );

  assign cmp_eq = a_imm ? (imm_val == b_bf) : (a_word == b_word);
  assign slt_a  = a_imm ? imm_val : a_bf;
  assign slt_lt = (slt_a < b_bf);

  always_comb begin
    next_pc  = pc_p1;
    kill     = 1'b0;
    split    = 1'b0;
    split_pc = a_addr;
    case (op)
      cw_pkg::OP_MOV, cw_pkg::OP_ADD, cw_pkg::OP_SUB: next_pc = pc_p1;
      cw_pkg::OP_JMP: next_pc = a_addr;
      cw_pkg::OP_JMZ: if (b_bf == '0) next_pc = a_addr;
      cw_pkg::OP_JMN: if (b_bf != '0) next_pc = a_addr;
      cw_pkg::OP_DJN: if (djn_bf != '0) next_pc = a_addr;
      cw_pkg::OP_CMP: if (cmp_eq) next_pc = pc_p2;
      cw_pkg::OP_SLT: if (slt_lt) next_pc = pc_p2;
      cw_pkg::OP_SPL: split = 1'b1;
      default: kill = 1'b1;
    endcase
  end
endmodule

// File: rtl/cw_exec_unit.sv
module cw_exec_unit
  import cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic [WORD_W-1:0] instr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_word,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_word,
  output logic              out_valid,
  output logic [ADDR_W-1:0] next_pc,
  output logic              kill,
  output logic              split,
  output logic [ADDR_W-1:0] split_pc,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [WORD_W-1:0] mem_wdata
);
  word_t ins, aw, bw, wd_c;
  logic  a_imm, we_c, kill_c, split_c;
  logic [ADDR_W-1:0] new_af, new_bf, np_c, spc_c;

  assign ins   = word_t'(instr);
  assign aw    = word_t'(a_word);
  assign bw    = word_t'(b_word);
  assign a_imm = (ins.amode == MD_IMM);

  cw_field_alu #(.M(CORE_SIZE), .W(ADDR_W)) u_alu (
    .op(ins.op), .a_imm(a_imm), .imm_val(ins.af),
    .a_af(aw.af), .a_bf(aw.bf), .b_af(bw.af), .b_bf(bw.bf),
    .new_af(new_af), .new_bf(new_bf)
  );

  cw_branch #(.M(CORE_SIZE), .W(ADDR_W), .WW(WORD_W)) u_br (
    .op(ins.op), .a_imm(a_imm), .pc(pc), .imm_val(ins.af),
    .a_addr(a_addr), .a_word(a_word), .a_bf(aw.bf),
    .b_word(b_word), .b_bf(bw.bf), .djn_bf(new_bf),
    .next_pc(np_c), .kill(kill_c), .split(split_c), .split_pc(spc_c)
  );

  always_comb begin
    wd_c = bw;
    we_c = 1'b0;
    case (ins.op)
      OP_MOV: begin
        we_c = 1'b1;
        if (a_imm) wd_c.bf = ins.af;
        else       wd_c = aw;
      end
      OP_ADD, OP_SUB: begin
        we_c = 1'b1;
        wd_c.bf = new_bf;
        if (!a_imm) wd_c.af = new_af;
      end
      OP_DJN: begin
        we_c = 1'b1;
        wd_c.bf = new_bf;
      end
      default: we_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      kill      <= 1'b0;
      split     <= 1'b0;
      mem_we    <= 1'b0;
      next_pc   <= '0;
      split_pc  <= '0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      out_valid <= in_valid;
      kill      <= in_valid & kill_c;
      split     <= in_valid & split_c;
      mem_we    <= in_valid & we_c;
      next_pc   <= np_c;
      split_pc  <= spc_c;
      mem_waddr <= b_addr;
      mem_wdata <= wd_c;
    end
  end

  // R2
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !mem_we && !kill && !split));
  // R3
  kill_excl_chk: assert property (@(posedge clk) disable iff (rst)
    kill |-> (!mem_we && !split));
  // R11
  split_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    split |-> !mem_we);
  // R12
  pc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(pc) < ADDR_W'(CORE_SIZE) && $past(a_addr) < ADDR_W'(CORE_SIZE))
      |-> (next_pc < ADDR_W'(CORE_SIZE)));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !mem_we && !kill && !split));
endmodule

// File: tb/cw_exec_unit_tb_top.sv
`timescale 1ns/1ps
module cw_exec_unit_tb_top;
  import cw_pkg::*;
  localparam int M = CORE_SIZE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [ADDR_W-1:0] pc = '0, a_addr = '0, b_addr = '0;
  logic [WORD_W-1:0] instr = '0, a_word = '0, b_word = '0;
  logic out_valid, kill, split, mem_we;
  logic [ADDR_W-1:0] next_pc, split_pc, mem_waddr;
  logic [WORD_W-1:0] mem_wdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cw_exec_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pc(pc), .instr(instr),
    .a_addr(a_addr), .a_word(a_word), .b_addr(b_addr), .b_word(b_word),
    .out_valid(out_valid), .next_pc(next_pc), .kill(kill), .split(split),
    .split_pc(split_pc), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  function automatic word_t mk(int op, int am, int bm, int af, int bf);
    word_t w;
    w.op = 4'(op); w.amode = 2'(am); w.bmode = 2'(bm);
    w.af = ADDR_W'(af); w.bf = ADDR_W'(bf);
    return w;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      1: return "R4";  2: return "R5";  3: return "R6";
      4, 5, 6: return "R7";  7: return "R8";  8: return "R9";
      9: return "R10"; 10: return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic ref_model(input int p, input word_t ins, input int aa,
                           input word_t aw, input word_t bw,
                           output int np, output bit ek, output bit es,
                           output int spc, output bit ewe, output word_t ewd);
    bit imm;
    int ia, nb, av;
    imm = (ins.amode == 2'd0);
    ia = int'(ins.af);
    np = (p + 1) % M; ek = 0; es = 0; spc = 0; ewe = 0; ewd = bw;
    case (int'(ins.op))
      1: begin ewe = 1; if (imm) ewd.bf = ADDR_W'(ia); else ewd = aw; end
      2: begin
        ewe = 1;
        if (imm) ewd.bf = ADDR_W'((int'(bw.bf) + ia) % M);
        else begin
          ewd.af = ADDR_W'((int'(bw.af) + int'(aw.af)) % M);
          ewd.bf = ADDR_W'((int'(bw.bf) + int'(aw.bf)) % M);
        end
      end
      3: begin
        ewe = 1;
        if (imm) ewd.bf = ADDR_W'((int'(bw.bf) + M - ia) % M);
        else begin
          ewd.af = ADDR_W'((int'(bw.af) + M - int'(aw.af)) % M);
          ewd.bf = ADDR_W'((int'(bw.bf) + M - int'(aw.bf)) % M);
        end
      end
      4: np = aa;
      5: if (bw.bf == 0) np = aa;
      6: if (bw.bf != 0) np = aa;
      7: begin
        nb = (int'(bw.bf) + M - 1) % M;
        ewe = 1; ewd.bf = ADDR_W'(nb);
        if (nb != 0) np = aa;
      end
      8: if (imm ? (ia == int'(bw.bf)) : (aw == bw)) np = (p + 2) % M;
      9: begin
        av = imm ? ia : int'(aw.bf);
        if (av < int'(bw.bf)) np = (p + 2) % M;
      end
      10: begin es = 1; spc = aa; end
      default: ek = 1;
    endcase
  endtask

  task automatic apply(input string tag, input int p, input word_t ins,
                       input int aa, input word_t aw, input int ba, input word_t bw);
    int np, spc;
    bit ek, es, ewe;
    word_t ewd;
    bit bad;
    ref_model(p, ins, aa, aw, bw, np, ek, es, spc, ewe, ewd);
    pc = ADDR_W'(p); instr = ins; a_addr = ADDR_W'(aa); a_word = aw;
    b_addr = ADDR_W'(ba); b_word = bw; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    bad = (out_valid !== 1'b1) || (kill !== ek) || (split !== es) ||
          (mem_we !== ewe) || (int'(next_pc) != np) ||
          (es && int'(split_pc) != spc) ||
          (ewe && (int'(mem_waddr) != ba || mem_wdata !== ewd));
    n_checks++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s op=%0d: got v=%b k=%b s=%b we=%b npc=%0d spc=%0d wa=%0d wd=%h, exp v=1 k=%b s=%b we=%b npc=%0d spc=%0d wa=%0d wd=%h",
        tag, ins.op, out_valid, kill, split, mem_we, next_pc, split_pc, mem_waddr,
        mem_wdata, ek, es, ewe, np, spc, ba, ewd);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    finish_run();
  end

  initial begin
    word_t x, y, z;
    void'($urandom(32'd20240611));
    // R1: reset holds outputs quiet even with in_valid high
    in_valid = 1'b1; instr = mk(10, 0, 0, 1, 2);
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 0 || mem_we !== 0 || kill !== 0 || split !== 0) begin
      n_fail++;
      $display("FAIL R1: got v=%b we=%b k=%b s=%b, exp all 0", out_valid, mem_we, kill, split);
    end
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 0 || mem_we !== 0 || kill !== 0 || split !== 0) begin
      n_fail++;
      $display("FAIL R1: got v=%b we=%b k=%b s=%b after reset, exp all 0", out_valid, mem_we, kill, split);
    end

    // R2: idle cycle with a MOV on the inputs gives no result
    instr = mk(1, 1, 1, 3, 4); in_valid = 1'b0;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 0 || mem_we !== 0 || kill !== 0 || split !== 0) begin
      n_fail++;
      $display("FAIL R2: got v=%b we=%b k=%b s=%b on idle, exp all 0", out_valid, mem_we, kill, split);
    end

    x = mk(0, 0, 0, 5, 6); y = mk(3, 1, 2, 7, 9);
    apply("R3", 12, mk(0, 0, 0, 1, 1), 40, x, 50, y);
    apply("R3", 12, mk(13, 1, 1, 1, 1), 40, x, 50, y);
    apply("R4", 100, mk(1, 0, 1, 77, 2), 100, x, 60, y);
    apply("R4", 100, mk(1, 1, 1, 77, 2), 30, x, 60, y);
    // R12: wrap on ADD and SUB fields
    apply("R12", 5, mk(2, 0, 1, 1, 0), 5, x, 9, mk(0, 0, 0, M-1, M-1));
    apply("R12", 5, mk(2, 1, 1, 1, 0), 5, mk(0, 0, 0, 3, 2), 9, mk(0, 0, 0, M-1, M-2));
    apply("R12", 5, mk(3, 0, 1, 4, 0), 5, x, 9, mk(0, 0, 0, 0, 1));
    apply("R6", 5, mk(3, 1, 1, 4, 0), 5, mk(0, 0, 0, 10, 20), 9, mk(0, 0, 0, 3, 25));
    apply("R7", 5, mk(5, 1, 1, 0, 0), 222, x, 9, mk(0, 0, 0, 3, 0));
    apply("R7", 5, mk(6, 1, 1, 0, 0), 222, x, 9, mk(0, 0, 0, 3, 0));
    apply("R8", 5, mk(7, 1, 1, 0, 0), 222, x, 9, mk(0, 0, 0, 3, 1));
    apply("R8", 5, mk(7, 1, 1, 0, 0), 222, x, 9, mk(0, 0, 0, 3, 0));
    apply("R9", 5, mk(8, 1, 1, 0, 0), 222, y, 9, y);
    apply("R9", 5, mk(8, 0, 1, 6, 0), 222, x, 9, mk(0, 0, 0, 3, 6));
    apply("R10", 5, mk(9, 0, 1, 6, 0), 222, x, 9, mk(0, 0, 0, 3, 6));
    apply("R10", 5, mk(9, 1, 1, 0, 0), 222, mk(0, 0, 0, 9, 5), 9, mk(0, 0, 0, 3, 6));
    apply("R11", 5, mk(10, 1, 1, 0, 0), 321, x, 9, y);
    apply("R12", M-1, mk(1, 1, 1, 0, 0), 3, x, 9, y);
    apply("R12", M-2, mk(8, 1, 1, 0, 0), 3, y, 9, y);
    apply("R12", M-1, mk(9, 0, 1, 0, 0), 3, x, 9, mk(0, 0, 0, 0, 1));

    for (int i = 0; i < 800; i++) begin
      int op;
      op = int'($urandom % 16);
      x = mk(int'($urandom % 16), int'($urandom % 4), int'($urandom % 4),
             int'($urandom % M), int'($urandom % M));
      y = mk(int'($urandom % 16), int'($urandom % 4), int'($urandom % 4),
             int'($urandom % M), int'($urandom % M));
      if ($urandom % 4 == 0) y.bf = '0;
      if ($urandom % 8 == 0) y.bf = ADDR_W'(1);
      if ($urandom % 5 == 0) y = x;
      z = mk(op, int'($urandom % 4), int'($urandom % 4),
             int'($urandom % M), int'($urandom % M));
      if ($urandom % 6 == 0) z.af = y.bf;
      apply(tag_of(op), int'($urandom % M), z, int'($urandom % M), x,
            int'($urandom % M), y);
      if ($urandom % 10 == 0) @(negedge clk);
    end
    finish_run();
  end
endmodule